// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the operand of a register-memory instruction from its addressing mode. Each request carries a mode code, a base register value, an index register value, a signed displacement or immediate field and a data-size code. The block returns one of three things: a register operand, an immediate operand, or a memory effective address. For autoincrement it also returns the updated base register value for writeback. The register file, the data memory and the ALU operation stay outside the block.

A request is accepted on a cycle where `start_i` and `ready_o` are both high. Every mode except memory indirect presents its result with a one-cycle `valid_o` pulse in the next cycle. Memory indirect first issues a read of the pointer at the base address. It keeps that read request up until the memory returns read-valid, then presents the fetched pointer as the effective address one cycle later. While a result is being presented, the block can accept a new request, so single-cycle requests can follow each other on consecutive cycles.

Top module: `ea_gen`

## Requirements
- R1: While and after reset, with no request, `ready_o` is 1 and `valid_o`, `mem_req_o` and `wb_en_o` are 0.
- R2: A request accepted with any mode other than 5 gives exactly one `valid_o` cycle, in the cycle right after acceptance. Requests accepted on consecutive cycles give results in the same order on consecutive cycles.
- R3: Mode 0 (register) gives `kind_o`=0 (register operand) and `result_o` equal to the base value.
- R4: Mode 1 (immediate) gives `kind_o`=1 (immediate operand) and `result_o` equal to the 16-bit displacement field sign-extended to 32 bits.
- R5: Mode 2 (displacement) gives `kind_o`=2 (address) and `result_o` = base + sign-extended displacement, modulo 2^32.
- R6: Mode 3 (register indirect) gives `kind_o`=2 and `result_o` equal to the base value.
- R7: Mode 4 (indexed) gives `kind_o`=2 and `result_o` = base + index, modulo 2^32.
- R8: Mode 5 (memory indirect) raises `mem_req_o` in the cycle after acceptance, with `mem_addr_o` equal to the base. It holds that request and address, with `ready_o` low, until `mem_rvalid_i` is seen. In the next cycle it drops `mem_req_o` and presents `kind_o`=2 with `result_o` equal to `mem_rdata_i`.
- R9: Mode 6 (autoincrement) gives `kind_o`=2 and `result_o` equal to the base. It sets `wb_en_o`=1 and `wb_val_o` = base + d, modulo 2^32. Here d is 1, 2, 4 or 8 for size codes 0, 1, 2 and 3.
- R10: Mode 7 (scaled) gives `kind_o`=2 and `result_o` = base + sign-extended displacement + index·d, modulo 2^32, with d taken from the size code as in R9.
- R11: `wb_en_o` is 1 only in a `valid_o` cycle of a mode-6 request. In every other result it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request valid |
| ready_o | output | 1 | Block can accept a request |
| mode_i | input | 3 | Addressing mode code 0..7 |
| size_i | input | 2 | Data size code (d = 1 << code) |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| disp_i | input | 16 | Signed displacement or immediate |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rvalid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | 32 | Pointer read data |
| valid_o | output | 1 | Result valid (one cycle) |
| kind_o | output | 2 | 0 register operand, 1 immediate, 2 address |
| result_o | output | 32 | Operand or effective address |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_val_o | output | 32 | New base register value |

## Verification
The bench builds the block with its default widths: a 32-bit address and a 16-bit displacement. With these, a displacement whose bit 15 is set reaches the sign-extension path. Bases near 2^32 reach the modulo wrap of the autoincrement and indexed sums, and index values scaled by 8 test the top shift amount. Memory-indirect requests are run with a read latency of zero cycles and of several cycles, so both the immediate reply and the held request are covered.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_IMM  = 3'd1,
    AM_DISP = 3'd2,
    AM_RIND = 3'd3,
    AM_IDX  = 3'd4,
    AM_MIND = 3'd5,
    AM_AINC = 3'd6,
    AM_SCL  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    RK_REGVAL = 2'd0,
    RK_IMMVAL = 2'd1,
    RK_ADDR   = 2'd2
  } rkind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } est_e;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic is_mind_i,
  input  logic mem_rvalid_i,
  output logic ready_o,
  output logic accept_o,
  output logic ptr_load_o,
  output logic mem_req_o,
  output logic valid_o
);
  est_e state_q, state_d;

  assign ready_o    = (state_q != ST_WAIT);
  assign accept_o   = start_i && ready_o;
  assign mem_req_o  = (state_q == ST_WAIT);
  assign ptr_load_o = mem_req_o && mem_rvalid_i;
  assign valid_o    = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept_o) state_d = is_mind_i ? ST_WAIT : ST_DONE;
        else          state_d = ST_IDLE;
      end
      ST_WAIT: begin
        if (mem_rvalid_i) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
  import ea_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int SZ_W   = 2
) (
  input  amode_e          mode_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   index_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [AW-1:0]   ptr_i,
  output rkind_e          kind_o,
  output logic [AW-1:0]   result_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o
);
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] step;
  logic [AW-1:0] idx_scaled;

  generate
    if (AW > DISP_W) begin : g_sext
      assign disp_ext = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[AW-1:0];
    end
  endgenerate

  assign step       = AW'(1) << size_i;
  assign idx_scaled = index_i << size_i;

  always_comb begin
    kind_o   = RK_ADDR;
    result_o = '0;
    wb_en_o  = 1'b0;
    wb_val_o = '0;
    unique case (mode_i)
      AM_REG: begin
        kind_o   = RK_REGVAL;
        result_o = base_i;
      end
      AM_IMM: begin
        kind_o   = RK_IMMVAL;
        result_o = disp_ext;
      end
      AM_DISP: result_o = base_i + disp_ext;
      AM_RIND: result_o = base_i;
      AM_IDX:  result_o = base_i + index_i;
      AM_MIND: result_o = ptr_i;
      AM_AINC: begin
        result_o = base_i;
        wb_en_o  = 1'b1;
        wb_val_o = base_i + step;
      end
      AM_SCL:  result_o = base_i + disp_ext + idx_scaled;
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  input  logic [2:0]        mode_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     index_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic [AW-1:0]     result_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o
);
  logic accept, ptr_load, valid_int, req_int;
  amode_e              mode_q;
  logic [SZ_W-1:0]     size_q;
  logic [AW-1:0]       base_q, index_q, ptr_q;
  logic [DISP_W-1:0]   disp_q;
  rkind_e              kind_c;
  logic [AW-1:0]       result_c, wb_val_c;
  logic                wb_en_c;

  ea_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .is_mind_i    (mode_i == AM_MIND),
    .mem_rvalid_i (mem_rvalid_i),
    .ready_o      (ready_o),
    .accept_o     (accept),
    .ptr_load_o   (ptr_load),
    .mem_req_o    (req_int),
    .valid_o      (valid_int)
  );

  // Operand capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= AM_REG;
      size_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      disp_q  <= '0;
    end else if (accept) begin
      mode_q  <= amode_e'(mode_i);
      size_q  <= size_i;
      base_q  <= base_i;
      index_q <= index_i;
      disp_q  <= disp_i;
    end
  end

  // Fetched pointer, enabled on read return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (ptr_load) ptr_q <= mem_rdata_i;
  end

  ea_addr_unit #(.AW(AW), .DISP_W(DISP_W), .SZ_W(SZ_W)) u_addr (
    .mode_i   (mode_q),
    .base_i   (base_q),
    .index_i  (index_q),
    .disp_i   (disp_q),
    .size_i   (size_q),
    .ptr_i    (ptr_q),
    .kind_o   (kind_c),
    .result_o (result_c),
    .wb_en_o  (wb_en_c),
    .wb_val_o (wb_val_c)
  );

  assign mem_req_o  = req_int;
  assign mem_addr_o = req_int ? base_q : '0;
  assign valid_o    = valid_int;
  assign kind_o     = valid_int ? kind_c : 2'd0;
  assign result_o   = valid_int ? result_c : '0;
  assign wb_en_o    = valid_int && wb_en_c;
  assign wb_val_o   = (valid_int && wb_en_c) ? wb_val_c : '0;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int SZ_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ready_o,
  input logic [2:0]        mode_i,
  input logic [AW-1:0]     base_i,
  input logic              mem_req_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [AW-1:0]     mem_rdata_i,
  input logic              valid_o,
  input logic [1:0]        kind_o,
  input logic [AW-1:0]     result_o,
  input logic              wb_en_o
);
  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o && mode_i != 3'd5) |=> valid_o);

  // R2
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(start_i && ready_o && mode_i != 3'd5) ||
                 $past(mem_req_o && mem_rvalid_i)));

  // R8
  ptr_req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o && mode_i == 3'd5) |=>
      (mem_req_o && mem_addr_o == $past(base_i)));

  // R8
  ptr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  ptr_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !ready_o);

  // R8
  ptr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rvalid_i) |=>
      (valid_o && !mem_req_o && kind_o == 2'd2 && result_o == $past(mem_rdata_i)));

  // R11
  wb_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (valid_o && kind_o == 2'd2));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DISP_W(DISP_W), .SZ_W(SZ_W)) u_ea_gen_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ready_o      (ready_o),
  .mode_i       (mode_i),
  .base_i       (base_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .valid_o      (valid_o),
  .kind_o       (kind_o),
  .result_o     (result_o),
  .wb_en_o      (wb_en_o)
);

// File: tb/test_ea_gen.sv
`timescale 1ns/1ps
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ready_o;
  logic [2:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] index_i = '0;
  logic [15:0] disp_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        valid_o;
  logic [1:0]  kind_o;
  logic [31:0] result_o;
  logic        wb_en_o;
  logic [31:0] wb_val_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] res;
    logic        wb;
    logic [31:0] wbv;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
    .mode_i(mode_i), .size_i(size_i), .base_i(base_i), .index_i(index_i),
    .disp_i(disp_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .valid_o(valid_o), .kind_o(kind_o), .result_o(result_o),
    .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [2:0] m, input logic [31:0] b,
                                 input logic [31:0] x, input logic [15:0] d,
                                 input logic [1:0] s, input string tag);
    exp_t e;
    logic [31:0] dsz;
    dsz = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : (s == 2'd2) ? 32'd4 : 32'd8;
    e.kind = 2'd2; e.res = '0; e.wb = 1'b0; e.wbv = '0; e.tag = tag;
    case (m)
      3'd0: begin e.kind = 2'd0; e.res = b; end
      3'd1: begin e.kind = 2'd1; e.res = sx(d); end
      3'd2: e.res = b + sx(d);
      3'd3: e.res = b;
      3'd4: e.res = b + x;
      3'd6: begin e.res = b; e.wb = 1'b1; e.wbv = b + dsz; end
      3'd7: e.res = b + sx(d) + x * dsz;
      default: e.res = '0;
    endcase
    return e;
  endfunction

  // Driver: called just after a falling edge, returns one cycle later
  task automatic send(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                      input logic [15:0] d, input logic [1:0] s, input string tag);
    sb.push_back(model(m, b, x, d, s, tag));
    mode_i = m; base_i = b; index_i = x; disp_i = d; size_i = s;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_ptr(input logic [31:0] b, input logic [31:0] ptr, input int lat);
    exp_t e;
    e.kind = 2'd2; e.res = ptr; e.wb = 1'b0; e.wbv = '0; e.tag = "R8";
    sb.push_back(e);
    mode_i = 3'd5; base_i = b; index_i = 32'h0; disp_i = 16'h0; size_i = 2'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 req", {31'b0, mem_req_o}, 32'd1);
    chk("R8 addr", mem_addr_o, b);
    chk("R8 ready low", {31'b0, ready_o}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R8 req held", {31'b0, mem_req_o}, 32'd1);
      chk("R8 addr held", mem_addr_o, b);
      chk("R8 no early valid", {31'b0, valid_o}, 32'd0);
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = ptr;
    @(negedge clk);
    mem_rvalid_i = 1'b0; mem_rdata_i = 32'h0;
    chk("R8 req dropped", {31'b0, mem_req_o}, 32'd0);
  endtask

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected valid expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " kind"}, {30'b0, kind_o}, {30'b0, e.kind});
        chk({e.tag, " result"}, result_o, e.res);
        chk({e.tag, " R11 wb_en"}, {31'b0, wb_en_o}, {31'b0, e.wb});
        if (e.wb) chk({e.tag, " wb_val"}, wb_val_o, e.wbv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", {31'b0, valid_o}, 32'd0);
    chk("R1 req in reset", {31'b0, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after reset
    chk("R1 ready", {31'b0, ready_o}, 32'd1);
    chk("R1 valid", {31'b0, valid_o}, 32'd0);
    chk("R1 wb_en", {31'b0, wb_en_o}, 32'd0);
    chk("R1 req", {31'b0, mem_req_o}, 32'd0);

    // R2 single pulse
    send(3'd2, 32'h0000_1000, 32'h0, 16'h0010, 2'd0, "R2/R5");
    @(negedge clk);
    chk("R2 single pulse", {31'b0, valid_o}, 32'd0);

    send(3'd0, 32'hDEAD_BEEF, 32'h1, 16'h1234, 2'd3, "R3");
    send(3'd1, 32'h5555_0000, 32'h0, 16'h8001, 2'd0, "R4");
    send(3'd1, 32'h0, 32'h0, 16'h7FFF, 2'd0, "R4");
    send(3'd2, 32'h0000_1000, 32'h0, 16'hFFF0, 2'd0, "R5");
    send(3'd3, 32'h8000_0004, 32'h9, 16'h0044, 2'd2, "R6");
    send(3'd4, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0, 2'd0, "R7");
    send(3'd6, 32'h0000_0100, 32'h0, 16'h0, 2'd0, "R9");
    send(3'd6, 32'h0000_0100, 32'h0, 16'h0, 2'd1, "R9");
    send(3'd6, 32'h0000_0100, 32'h0, 16'h0, 2'd2, "R9");
    send(3'd6, 32'hFFFF_FFFC, 32'h0, 16'h0, 2'd3, "R9");
    send(3'd7, 32'h0002_0000, 32'h0000_0005, 16'hFFF8, 2'd3, "R10");
    send(3'd7, 32'h0000_4000, 32'h0000_0003, 16'h0100, 2'd1, "R10");
    @(negedge clk);

    send_ptr(32'h0000_2000, 32'hCAFE_0010, 0);
    send_ptr(32'h0000_3000, 32'h1234_5678, 3);
    send(3'd4, 32'h0000_0010, 32'h0000_0001, 16'h0, 2'd0, "R2/R7 after ptr");
    @(negedge clk);
    chk("R1 idle ready", {31'b0, ready_o}, 32'd1);
    chk("R2 all results seen", sb.size(), 32'd0);
    finish_run();
  end
endmodule